// File: doc/BRIEF.md
# Display Timing Register Bank with Flat-Panel Adjustment

This block is the byte-wide I/O register front end of a character-cell display controller. Software reaches the standard timing registers indirectly: it writes a register number to an index port and then reads or writes that register through the neighbouring data port. Mode, colour and status bytes sit at their own ports. A second index/data pair holds two panel parameters: a signed horizontal sync offset and the number of characters the panel takes in per scanline.

A select input tells the block which display is attached. With the external monitor, the effective horizontal values driven to the timing generator are the programmed timing register values, unchanged. With the flat panel, the sync position is the programmed value plus the signed offset, and the characters-per-line value comes from the panel parameter. Software can therefore keep writing ordinary monitor timings while a panel with different timing is attached. The panel parameters are written once, each time the display selection changes. A flag reports when the adjusted sync position falls past the last column the panel has.

Top module: `vidreg_panel_top`

## Requirements
- R1: A byte write to port 0x3D4 loads the timing index with data bits [4:0] and ignores the upper bits. Reading 0x3D4 returns the index zero-extended. Port 0x3D5 reads and writes the timing register that the index selects, for indices 0 through 17.
- R2: With a timing index of 18 to 31, reads of 0x3D5 return 0xFF and writes to 0x3D5 change no register.
- R3: Port 0x3D8 (mode) and port 0x3D9 (colour) are full 8-bit read/write registers.
- R4: Port 0x3DA reads as status. Bit 0 is the display-enable input, bit 3 is the vertical-retrace input and all other bits are 0. Writes to it are ignored and reading it changes no state.
- R5: Port 0x3DD loads a 6-bit panel index from data bits [5:0]. Port 0x3DE accesses panel register 0x21 (characters per line) and panel register 0x31 (sync offset). Any other panel index reads 0xFF and ignores writes.
- R6: With panel_sel low, eff_htotal equals timing register 0, eff_chars equals timing register 1, eff_hsync equals timing register 2, and hsync_oor is 0.
- R7: With panel_sel high, eff_hsync equals (timing register 2 + sync offset) modulo 256, with the offset taken as two's complement, and eff_chars equals panel register 0x21. eff_htotal still equals timing register 0.
- R8: hsync_oor is 1 exactly when panel_sel is high and eff_hsync is greater than LAST_COL.
- R9: A synchronous active-high reset loads the 80x25 text defaults and clears both indices. The timing register defaults are 0x71, 0x50, 0x5A, 0x0A, 0x1F, 0x06, 0x19, 0x1C, 0x02, 0x07, 0x06, 0x07 and zeros after that. Mode resets to 0x29, colour to 0x30, characters per line to 0x50 and the sync offset to 0.
- R10: A 16-bit write issued as a byte to 0x3D4 followed by a byte to 0x3D5 sets both index and data. The index holds, so later 0x3D5 accesses reach the same register.
- R11: Reads of any other port address return 0xFF, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | I/O port address |
| io_wr | input | 1 | Byte write strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| panel_sel | input | 1 | 1 = flat panel, 0 = external monitor |
| disp_en_in | input | 1 | Display-enable status input |
| vretrace_in | input | 1 | Vertical-retrace status input |
| mode_q | output | 8 | Mode register |
| color_q | output | 8 | Colour register |
| eff_htotal | output | 8 | Effective horizontal total |
| eff_hsync | output | 8 | Effective horizontal sync position |
| eff_chars | output | 8 | Effective characters per line |
| hsync_oor | output | 1 | Adjusted sync position is past the last panel column |

## Verification
The bench builds the block with its default parameters: 18 timing registers, a 5-bit timing index, a 6-bit panel index and LAST_COL = 0x59. With these values the reset sync position 0x5A is already out of range on the panel when the offset is zero. An offset of -8 brings it to 0x52 and an offset of -4 brings it to 0x56, both in range, so the flag boundary is tested with the reset timing. The bench also tests graphics-width sync values, an offset that wraps past 0xFF, undefined indices of both banks, and an index byte whose upper bits are set.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

    localparam int IO_ADDR_W = 10;

    localparam logic [IO_ADDR_W-1:0] PORT_CRTC_IDX = 10'h3D4;
    localparam logic [IO_ADDR_W-1:0] PORT_CRTC_DAT = 10'h3D5;
    localparam logic [IO_ADDR_W-1:0] PORT_MODE     = 10'h3D8;
    localparam logic [IO_ADDR_W-1:0] PORT_COLOR    = 10'h3D9;
    localparam logic [IO_ADDR_W-1:0] PORT_STATUS   = 10'h3DA;
    localparam logic [IO_ADDR_W-1:0] PORT_EXT_IDX  = 10'h3DD;
    localparam logic [IO_ADDR_W-1:0] PORT_EXT_DAT  = 10'h3DE;

    localparam logic [7:0] MODE_RESET  = 8'h29;
    localparam logic [7:0] COLOR_RESET = 8'h30;
    localparam logic [7:0] CHARS_RESET = 8'h50;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_CIDX, SEL_CDAT, SEL_MODE,
        SEL_COLOR, SEL_STATUS, SEL_XIDX, SEL_XDAT
    } port_sel_e;

    typedef struct packed {
        logic [7:0] htotal;
        logic [7:0] hdisp;
        logic [7:0] hsync;
    } crtc_horiz_t;

    typedef struct packed {
        logic [7:0] chars;
        logic [7:0] hdelta;
    } panel_cfg_t;

    typedef struct packed {
        logic [7:0] htotal;
        logic [7:0] hsync;
        logic [7:0] chars;
        logic       oor;
    } eff_timing_t;

    function automatic port_sel_e decode_port(logic [IO_ADDR_W-1:0] a);
        case (a)
            PORT_CRTC_IDX: return SEL_CIDX;
            PORT_CRTC_DAT: return SEL_CDAT;
            PORT_MODE:     return SEL_MODE;
            PORT_COLOR:    return SEL_COLOR;
            PORT_STATUS:   return SEL_STATUS;
            PORT_EXT_IDX:  return SEL_XIDX;
            PORT_EXT_DAT:  return SEL_XDAT;
            default:       return SEL_NONE;
        endcase
    endfunction

    // 80x25 text timing defaults
    function automatic logic [7:0] crtc_default(int idx);
        case (idx)
            0:  return 8'h71;
            1:  return 8'h50;
            2:  return 8'h5A;
            3:  return 8'h0A;
            4:  return 8'h1F;
            5:  return 8'h06;
            6:  return 8'h19;
            7:  return 8'h1C;
            8:  return 8'h02;
            9:  return 8'h07;
            10: return 8'h06;
            11: return 8'h07;
            default: return 8'h00;
        endcase
    endfunction

    // two's-complement offset, result wraps modulo 256
    function automatic logic [7:0] apply_delta(logic [7:0] pos, logic [7:0] delta);
        return pos + delta;
    endfunction

endpackage

// File: rtl/vidreg_crtc_bank.sv
module vidreg_crtc_bank
    import vidreg_pkg::*;
#(
    parameter int NREGS = 18,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [7:0]       rd_data,
    output crtc_horiz_t      horiz
);

    logic [7:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= idx_wdata;
        end
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= crtc_default(i);
            end else if (dat_we && (idx_q == IDX_W'(i))) begin
                regs[i] <= dat_wdata;
            end
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < NREGS; i++) begin
            if (idx_q == IDX_W'(i)) begin
                rd_data = regs[i];
            end
        end
    end

    assign horiz.htotal = regs[0];
    assign horiz.hdisp  = regs[1];
    assign horiz.hsync  = regs[2];

endmodule

// File: rtl/vidreg_ext_bank.sv
module vidreg_ext_bank
    import vidreg_pkg::*;
#(
    parameter int              IDX_W     = 6,
    parameter logic [IDX_W-1:0] IDX_CHARS = 6'h21,
    parameter logic [IDX_W-1:0] IDX_DELTA = 6'h31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] idx_wdata,
    input  logic             dat_we,
    input  logic [7:0]       dat_wdata,
    output logic [IDX_W-1:0] idx_q,
    output logic [7:0]       rd_data,
    output panel_cfg_t       cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            cfg.chars  <= CHARS_RESET;
            cfg.hdelta <= 8'h00;
        end else begin
            if (idx_we) begin
                idx_q <= idx_wdata;
            end
            if (dat_we && idx_q == IDX_CHARS) begin
                cfg.chars <= dat_wdata;
            end
            if (dat_we && idx_q == IDX_DELTA) begin
                cfg.hdelta <= dat_wdata;
            end
        end
    end

    always_comb begin
        case (idx_q)
            IDX_CHARS: rd_data = cfg.chars;
            IDX_DELTA: rd_data = cfg.hdelta;
            default:   rd_data = 8'hFF;
        endcase
    end

endmodule

// File: rtl/vidreg_timing_sel.sv
module vidreg_timing_sel
    import vidreg_pkg::*;
#(
    parameter logic [7:0] LAST_COL = 8'h59
) (
    input  logic        panel_sel,
    input  crtc_horiz_t horiz,
    input  panel_cfg_t  cfg,
    output eff_timing_t eff
);

    logic [7:0] adj_sync;

    assign adj_sync = apply_delta(horiz.hsync, cfg.hdelta);

    always_comb begin
        eff.htotal = horiz.htotal;
        if (panel_sel) begin
            eff.hsync = adj_sync;
            eff.chars = cfg.chars;
            eff.oor   = (adj_sync > LAST_COL);
        end else begin
            eff.hsync = horiz.hsync;
            eff.chars = horiz.hdisp;
            eff.oor   = 1'b0;
        end
    end

endmodule

// File: rtl/vidreg_panel_top.sv
module vidreg_panel_top
    import vidreg_pkg::*;
#(
    parameter int         CRTC_REGS  = 18,
    parameter int         CRTC_IDX_W = 5,
    parameter int         EXT_IDX_W  = 6,
    parameter logic [7:0] LAST_COL   = 8'h59
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic                 io_wr,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    input  logic                 panel_sel,
    input  logic                 disp_en_in,
    input  logic                 vretrace_in,
    output logic [7:0]           mode_q,
    output logic [7:0]           color_q,
    output logic [7:0]           eff_htotal,
    output logic [7:0]           eff_hsync,
    output logic [7:0]           eff_chars,
    output logic                 hsync_oor
);

    port_sel_e             sel;
    logic [CRTC_IDX_W-1:0] crtc_idx;
    logic [EXT_IDX_W-1:0]  ext_idx;
    logic [7:0]            crtc_rd;
    logic [7:0]            ext_rd;
    crtc_horiz_t           horiz;
    panel_cfg_t            cfg;
    eff_timing_t           eff;

    assign sel = decode_port(io_addr);

    vidreg_crtc_bank #(
        .NREGS (CRTC_REGS),
        .IDX_W (CRTC_IDX_W)
    ) u_crtc (
        .clk       (clk),
        .rst       (rst),
        .idx_we    (io_wr && sel == SEL_CIDX),
        .idx_wdata (io_wdata[CRTC_IDX_W-1:0]),
        .dat_we    (io_wr && sel == SEL_CDAT),
        .dat_wdata (io_wdata),
        .idx_q     (crtc_idx),
        .rd_data   (crtc_rd),
        .horiz     (horiz)
    );

    vidreg_ext_bank #(
        .IDX_W     (EXT_IDX_W),
        .IDX_CHARS (EXT_IDX_W'(8'h21)),
        .IDX_DELTA (EXT_IDX_W'(8'h31))
    ) u_ext (
        .clk       (clk),
        .rst       (rst),
        .idx_we    (io_wr && sel == SEL_XIDX),
        .idx_wdata (io_wdata[EXT_IDX_W-1:0]),
        .dat_we    (io_wr && sel == SEL_XDAT),
        .dat_wdata (io_wdata),
        .idx_q     (ext_idx),
        .rd_data   (ext_rd),
        .cfg       (cfg)
    );

    vidreg_timing_sel #(
        .LAST_COL (LAST_COL)
    ) u_sel (
        .panel_sel (panel_sel),
        .horiz     (horiz),
        .cfg       (cfg),
        .eff       (eff)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_RESET;
            color_q <= COLOR_RESET;
        end else if (io_wr) begin
            if (sel == SEL_MODE)  mode_q  <= io_wdata;
            if (sel == SEL_COLOR) color_q <= io_wdata;
        end
    end

    always_comb begin
        case (sel)
            SEL_CIDX:   io_rdata = 8'(crtc_idx);
            SEL_CDAT:   io_rdata = crtc_rd;
            SEL_MODE:   io_rdata = mode_q;
            SEL_COLOR:  io_rdata = color_q;
            SEL_STATUS: io_rdata = {4'b0000, vretrace_in, 2'b00, disp_en_in};
            SEL_XIDX:   io_rdata = 8'(ext_idx);
            SEL_XDAT:   io_rdata = ext_rd;
            default:    io_rdata = 8'hFF;
        endcase
    end

    assign eff_htotal = eff.htotal;
    assign eff_hsync  = eff.hsync;
    assign eff_chars  = eff.chars;
    assign hsync_oor  = eff.oor;

endmodule

// File: rtl/vidreg_chk.sv
module vidreg_chk
    import vidreg_pkg::*;
#(
    parameter int         CRTC_REGS  = 18,
    parameter int         CRTC_IDX_W = 5,
    parameter int         EXT_IDX_W  = 6,
    parameter logic [7:0] LAST_COL   = 8'h59
) (
    input logic                  clk,
    input logic                  rst,
    input logic [IO_ADDR_W-1:0]  io_addr,
    input logic                  io_wr,
    input logic [7:0]            io_rdata,
    input logic                  panel_sel,
    input logic                  disp_en_in,
    input logic                  vretrace_in,
    input logic [7:0]            eff_htotal,
    input logic [7:0]            eff_hsync,
    input logic [7:0]            eff_chars,
    input logic                  hsync_oor,
    input logic [CRTC_IDX_W-1:0] crtc_idx,
    input logic [EXT_IDX_W-1:0]  ext_idx
);

    assert_status_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (io_addr == PORT_STATUS) |->
            (io_rdata[0] == disp_en_in && io_rdata[3] == vretrace_in &&
             $countones(io_rdata) <= 2));

    assert_oor_only_panel_R8: assert property (@(posedge clk) disable iff (rst)
        hsync_oor |-> (panel_sel && eff_hsync > LAST_COL));

    assert_oor_raised_R8: assert property (@(posedge clk) disable iff (rst)
        (panel_sel && eff_hsync > LAST_COL) |-> hsync_oor);

    assert_undef_crtc_write_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_CRTC_DAT && crtc_idx >= CRTC_IDX_W'(CRTC_REGS)) |=>
            (($stable(eff_htotal) && $stable(eff_hsync) && $stable(eff_chars)) ||
             !$stable(panel_sel)));

    assert_undef_ext_write_R5: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == PORT_EXT_DAT &&
         ext_idx != EXT_IDX_W'(8'h21) && ext_idx != EXT_IDX_W'(8'h31)) |=>
            (($stable(eff_hsync) && $stable(eff_chars)) || !$stable(panel_sel)));

    assert_monitor_ignores_panel_R6: assert property (@(posedge clk) disable iff (rst)
        (!panel_sel && io_wr && io_addr == PORT_EXT_DAT) |=>
            (($stable(eff_hsync) && $stable(eff_chars) && !hsync_oor) || panel_sel));

    assert_reset_defaults_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |->
            (eff_htotal == 8'h71 && eff_hsync == 8'h5A && eff_chars == 8'h50));

endmodule

bind vidreg_panel_top vidreg_chk #(
    .CRTC_REGS  (CRTC_REGS),
    .CRTC_IDX_W (CRTC_IDX_W),
    .EXT_IDX_W  (EXT_IDX_W),
    .LAST_COL   (LAST_COL)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .io_addr     (io_addr),
    .io_wr       (io_wr),
    .io_rdata    (io_rdata),
    .panel_sel   (panel_sel),
    .disp_en_in  (disp_en_in),
    .vretrace_in (vretrace_in),
    .eff_htotal  (eff_htotal),
    .eff_hsync   (eff_hsync),
    .eff_chars   (eff_chars),
    .hsync_oor   (hsync_oor),
    .crtc_idx    (crtc_idx),
    .ext_idx     (ext_idx)
);

// File: tb/sim_vidreg_panel_top.sv
`timescale 1ns/1ps
module sim_vidreg_panel_top;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] io_addr = 10'h000;
    logic       io_wr = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic [7:0] io_rdata;
    logic       panel_sel = 1'b0;
    logic       disp_en_in = 1'b0;
    logic       vretrace_in = 1'b0;
    logic [7:0] mode_q, color_q, eff_htotal, eff_hsync, eff_chars;
    logic       hsync_oor;

    int checks = 0;
    int fails = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    // reference model state
    int m_crtc [32];
    int m_ext [64];
    int m_cidx, m_xidx, m_mode, m_color;

    always #(CLK_NS/2) clk = ~clk;

    vidreg_panel_top u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .panel_sel(panel_sel),
        .disp_en_in(disp_en_in), .vretrace_in(vretrace_in),
        .mode_q(mode_q), .color_q(color_q), .eff_htotal(eff_htotal),
        .eff_hsync(eff_hsync), .eff_chars(eff_chars), .hsync_oor(hsync_oor)
    );

    function automatic int crtc_init(int i);
        int t [12] = '{'h71, 'h50, 'h5A, 'h0A, 'h1F, 'h06, 'h19, 'h1C, 'h02, 'h07, 'h06, 'h07};
        return (i < 12) ? t[i] : 0;
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < 32; i++) m_crtc[i] = (i < 18) ? crtc_init(i) : 'hFF;
        for (int i = 0; i < 64; i++) m_ext[i] = 'hFF;
        m_ext['h21] = 'h50;
        m_ext['h31] = 0;
        m_cidx = 0; m_xidx = 0; m_mode = 'h29; m_color = 'h30;
    endfunction

    function automatic int model_read(int a);
        case (a)
            'h3D4: return m_cidx;
            'h3D5: return m_crtc[m_cidx];
            'h3D8: return m_mode;
            'h3D9: return m_color;
            'h3DA: return (vretrace_in ? 8 : 0) + (disp_en_in ? 1 : 0);
            'h3DD: return m_xidx;
            'h3DE: return m_ext[m_xidx];
            default: return 'hFF;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        running = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        running = 1'b1;
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        io_addr = 10'(a);
        io_wdata = 8'(d);
        io_wr = 1'b1;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
        case (a)
            'h3D4: m_cidx = d & 31;
            'h3D5: if (m_cidx < 18) m_crtc[m_cidx] = d;
            'h3D8: m_mode = d;
            'h3D9: m_color = d;
            'h3DD: m_xidx = d & 63;
            'h3DE: if (m_xidx == 'h21 || m_xidx == 'h31) m_ext[m_xidx] = d;
            default: ;
        endcase
    endtask

    // byte-split word write: low byte to the port, high byte to port + 1
    task automatic wr_word(int a, int w);
        wr(a, w & 'hFF);
        wr(a + 1, (w >> 8) & 'hFF);
    endtask

    task automatic rd_check(string req, int a);
        @(negedge clk);
        io_addr = 10'(a);
        io_wr = 1'b0;
        #2;
        check(req, int'(io_rdata), model_read(a));
    endtask

    task automatic set_panel(bit v);
        @(negedge clk);
        panel_sel = v;
    endtask

    // per-clock comparison of the effective timing outputs (R6, R7, R8)
    always @(negedge clk) begin
        #5;
        if (running && !rst) begin
            int hs, ch, oor;
            string rq;
            if (panel_sel) begin
                hs = (m_crtc[2] + m_ext['h31]) % 256;
                ch = m_ext['h21];
                oor = (hs > 'h59) ? 1 : 0;
                rq = "R7";
            end else begin
                hs = m_crtc[2];
                ch = m_crtc[1];
                oor = 0;
                rq = "R6";
            end
            check(rq, int'(eff_htotal), m_crtc[0]);
            check(rq, int'(eff_hsync), hs);
            check(rq, int'(eff_chars), ch);
            check("R8", int'(hsync_oor), oor);
        end
    end

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        do_reset();

        // R9: reset state of every readable register
        rd_check("R9", 'h3D4);
        for (int i = 0; i < 18; i++) begin
            wr('h3D4, i);
            rd_check("R9", 'h3D5);
        end
        rd_check("R9", 'h3D8);
        rd_check("R9", 'h3D9);
        rd_check("R9", 'h3DD);
        wr('h3DD, 'h21); rd_check("R9", 'h3DE);
        wr('h3DD, 'h31); rd_check("R9", 'h3DE);
        check("R9 mode_q", int'(mode_q), 'h29);
        check("R9 color_q", int'(color_q), 'h30);

        // R1: index keeps only bits [4:0]
        wr('h3D4, 'hE2);
        rd_check("R1", 'h3D4);
        rd_check("R1", 'h3D5);

        // R10: split word write sets index and data, index persists
        wr_word('h3D4, 'h3C0C);
        rd_check("R10", 'h3D5);
        wr('h3D5, 'h3D);
        rd_check("R10", 'h3D4);
        rd_check("R10", 'h3D5);

        // R2: undefined timing index
        wr('h3D4, 20);
        rd_check("R2", 'h3D5);
        wr('h3D5, 'h12);
        rd_check("R2", 'h3D5);
        wr('h3D4, 31);
        wr('h3D5, 'h00);
        rd_check("R2", 'h3D5);
        for (int i = 0; i < 18; i++) begin
            wr('h3D4, i);
            rd_check("R2", 'h3D5);
        end

        // R3: mode and colour
        wr('h3D8, 'h1A); wr('h3D9, 'hC5);
        rd_check("R3", 'h3D8); rd_check("R3", 'h3D9);
        check("R3 mode_q", int'(mode_q), 'h1A);
        check("R3 color_q", int'(color_q), 'hC5);

        // R4: status follows inputs, write ignored
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            disp_en_in = p[0];
            vretrace_in = p[1];
            rd_check("R4", 'h3DA);
            rd_check("R4", 'h3DA);
        end
        wr('h3DA, 'hFF);
        rd_check("R4", 'h3DA);
        rd_check("R4", 'h3D8);
        rd_check("R4", 'h3D9);

        // R11: unmapped port
        rd_check("R11", 'h3DB);
        rd_check("R11", 'h3D0);
        wr('h3DB, 'h77);
        wr('h3D0, 'h66);
        rd_check("R11", 'h3D8);
        rd_check("R11", 'h3D9);
        rd_check("R11", 'h3D4);

        // R6/R7/R8: default sync 0x5A on panel, zero offset is out of range
        set_panel(1'b1);
        repeat (3) @(posedge clk);
        // offset -8 gives 0x52
        wr_word('h3DD, 'hF831);
        repeat (2) @(posedge clk);
        rd_check("R5", 'h3DE);
        // offset -4 gives 0x56
        wr('h3DE, 'hFC);
        repeat (2) @(posedge clk);
        // offset +1 gives 0x5B, out of range
        wr('h3DE, 'h01);
        // graphics-width sync 0x2D with offset -1 gives 0x2C
        wr('h3DE, 'hFF);
        wr_word('h3D4, 'h2D02);
        repeat (2) @(posedge clk);
        // wrap: 0xFE + 5 = 0x03
        wr('h3D5, 'hFE);
        wr_word('h3DD, 'h0531);
        repeat (2) @(posedge clk);
        // characters per line one below the line width
        wr_word('h3DD, 'h4F21);
        rd_check("R5", 'h3DE);
        repeat (2) @(posedge clk);

        // R5: undefined panel index, and index masking
        wr('h3DD, 'h10);
        rd_check("R5", 'h3DE);
        wr('h3DE, 'h44);
        rd_check("R5", 'h3DE);
        wr('h3DD, 'hE1);
        rd_check("R5", 'h3DD);
        rd_check("R5", 'h3DE);

        // R6: back to monitor, panel writes have no effect on outputs
        set_panel(1'b0);
        repeat (2) @(posedge clk);
        wr_word('h3DD, 'h8031);
        repeat (2) @(posedge clk);
        check("R6 oor", int'(hsync_oor), 0);
        set_panel(1'b1);
        repeat (2) @(posedge clk);
        set_panel(1'b0);

        // R9: reset mid-run restores defaults
        do_reset();
        rd_check("R9", 'h3D4);
        wr('h3D4, 2);
        rd_check("R9", 'h3D5);
        wr('h3DD, 'h21);
        rd_check("R9", 'h3DE);
        set_panel(1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        #6;
        check("R9 oor", int'(hsync_oor), 1);

        repeat (3) @(posedge clk);
        done = 1'b1;
        running = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule